// File: doc/BRIEF.md
# Dual-Mode Signed Multiplier

This block is a hard-multiplier-style arithmetic unit. It either forms one 18x18 product, 36 bits wide, or it splits into two independent 9x9 multipliers. In the split configuration each narrow product is 18 bits wide, and both are packed side by side into the same 36-bit result. Two control inputs set whether operand X and operand Y are each treated as two's-complement or unsigned.

Two optional register stages sit in the datapath. Elaboration parameters select each one, so the block has a fixed latency of zero, one or two cycles. The first stage captures the operands, the mode and the sign controls. The second stage captures the product. Both stages share one clock and one clock enable. They also share one active-low clear, which empties them at once and is released in step with the clock.

Top module: `dual_mode_mult`

## Requirements
- R1: With `split_mode` = 0, `product` equals the full 36-bit product of `x_in` and `y_in`. Each operand is 18 bits wide and is sign-extended when its control (`x_signed`, `y_signed`) is 1, and zero-extended when it is 0.
- R2: With `split_mode` = 1, `product[17:0]` is the product of `x_in[8:0]` and `y_in[8:0]`, and `product[35:18]` is the product of `x_in[17:9]` and `y_in[17:9]`.
- R3: In split mode, `x_signed` governs the signedness of both 9-bit halves of X, and `y_signed` governs both halves of Y.
- R4: In split mode the two lanes are independent. A negative or large result in one lane never changes the bits of the other lane.
- R5: Latency equals the number of enabled stages. Parameter `IN_REG` enables the operand stage and `OUT_REG` enables the product stage. With both enabled, a value applied before clock edge k appears after edge k+1.
- R6: While `ce` is 0, the enabled register stages hold their contents, and input changes do not reach a registered `product`.
- R7: Driving `rst_n` low forces every enabled stage to zero without waiting for a clock. After `rst_n` rises, the stages resume loading two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both register stages |
| rst_n | input | 1 | Active-low asynchronous clear, released synchronously |
| ce | input | 1 | Clock enable for both register stages |
| split_mode | input | 1 | 0: one 18x18 product; 1: two 9x9 products |
| x_signed | input | 1 | 1: operand X is two's-complement |
| y_signed | input | 1 | 1: operand Y is two's-complement |
| x_in | input | 18 | Operand X (two 9-bit halves in split mode) |
| y_in | input | 18 | Operand Y (two 9-bit halves in split mode) |
| product | output | 36 | Product, or two packed 18-bit products |

## Verification
The bench drives three instances together: one with no register stages, one with only the operand stage, and one with both. Each vector is applied just after a falling clock edge. The unregistered result is sampled 1 ns later. The single-stage result is sampled after the next rising edge, and the two-stage result after the rising edge after that. In a streaming run the inputs change every cycle, so each instance is compared with the vector applied zero, one or two cycles earlier. A one-cycle slip in either direction fails that comparison. Clear and clock-enable checks count the two rising edges needed for clear release and pipeline refill before they look at the output.

// File: rtl/dual_mode_mult_pkg.sv
package dual_mode_mult_pkg;
  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } mult_mode_e;
endpackage

// File: rtl/dmm_reset_sync.sv
module dmm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dmm_pipe_reg.sv
module dmm_pipe_reg #(
  parameter int W      = 8,
  parameter bit ENABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (ENABLE) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      always_comb begin
        q_nxt = ce ? d : q_r;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q = q_r;

      // R6: a disabled clock enable freezes the stage
      assert_ce_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(q_r));
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/dmm_core.sv
module dmm_core
  import dual_mode_mult_pkg::*;
#(
  parameter int HALF_W = 9,
  localparam int OP_W   = 2 * HALF_W,
  localparam int LANE_W = 2 * HALF_W,
  localparam int PROD_W = 2 * OP_W
) (
  input  mult_mode_e        mode,
  input  logic              x_signed,
  input  logic              y_signed,
  input  logic [OP_W-1:0]   x,
  input  logic [OP_W-1:0]   y,
  output logic [PROD_W-1:0] p
);
  logic [PROD_W-1:0] x_ext;
  logic [PROD_W-1:0] y_ext;
  logic [PROD_W-1:0] wide_p;
  logic [PROD_W-1:0] split_p;

  // wide lane: extend to the product width, then truncate modulo 2^PROD_W
  always_comb begin
    x_ext  = {{(PROD_W-OP_W){x_signed & x[OP_W-1]}}, x};
    y_ext  = {{(PROD_W-OP_W){y_signed & y[OP_W-1]}}, y};
    wide_p = x_ext * y_ext;
  end

  // narrow lanes: each half has its own multiplier, no carry between them
  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [HALF_W-1:0] xh;
      logic [HALF_W-1:0] yh;
      logic [LANE_W-1:0] xh_ext;
      logic [LANE_W-1:0] yh_ext;
      always_comb begin
        xh     = x[g*HALF_W +: HALF_W];
        yh     = y[g*HALF_W +: HALF_W];
        xh_ext = {{(LANE_W-HALF_W){x_signed & xh[HALF_W-1]}}, xh};
        yh_ext = {{(LANE_W-HALF_W){y_signed & yh[HALF_W-1]}}, yh};
        split_p[g*LANE_W +: LANE_W] = xh_ext * yh_ext;
      end
    end
  endgenerate

  always_comb begin
    p = (mode == MODE_SPLIT) ? split_p : wide_p;
  end
endmodule

// File: rtl/dual_mode_mult.sv
module dual_mode_mult
  import dual_mode_mult_pkg::*;
#(
  parameter int HALF_W  = 9,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int OP_W   = 2 * HALF_W,
  localparam int LANE_W = 2 * HALF_W,
  localparam int PROD_W = 2 * OP_W,
  localparam int IN_W   = 2 * OP_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              split_mode,
  input  logic              x_signed,
  input  logic              y_signed,
  input  logic [OP_W-1:0]   x_in,
  input  logic [OP_W-1:0]   y_in,
  output logic [PROD_W-1:0] product
);
  logic              rst_int_n;
  logic [IN_W-1:0]   in_d;
  logic [IN_W-1:0]   in_q;
  logic              mode_r;
  logic              xs_r;
  logic              ys_r;
  logic [OP_W-1:0]   x_r;
  logic [OP_W-1:0]   y_r;
  logic [PROD_W-1:0] p_comb;
  mult_mode_e        mode_e;

  dmm_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign in_d = {split_mode, x_signed, y_signed, x_in, y_in};

  dmm_pipe_reg #(.W(IN_W), .ENABLE(IN_REG)) u_in_stage (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ce    (ce),
    .d     (in_d),
    .q     (in_q)
  );

  assign {mode_r, xs_r, ys_r, x_r, y_r} = in_q;
  assign mode_e = mult_mode_e'(mode_r);

  dmm_core #(.HALF_W(HALF_W)) u_core (
    .mode     (mode_e),
    .x_signed (xs_r),
    .y_signed (ys_r),
    .x        (x_r),
    .y        (y_r),
    .p        (p_comb)
  );

  dmm_pipe_reg #(.W(PROD_W), .ENABLE(OUT_REG)) u_out_stage (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ce    (ce),
    .d     (p_comb),
    .q     (product)
  );

  // R1: signed wide product of nonzero operands carries the xor of signs
  assert_wide_sign_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_e == MODE_WIDE && xs_r && ys_r && x_r != '0 && y_r != '0)
      |-> (p_comb[PROD_W-1] == (x_r[OP_W-1] ^ y_r[OP_W-1])));

  // R2: a zero upper half on X leaves the upper lane zero
  assert_split_upper_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_e == MODE_SPLIT && x_r[OP_W-1:HALF_W] == '0)
      |-> (p_comb[PROD_W-1:LANE_W] == '0));

  // R3: each lane follows both sign controls
  assert_split_sign_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_e == MODE_SPLIT && xs_r && ys_r &&
     x_r[HALF_W-1:0] != '0 && y_r[HALF_W-1:0] != '0)
      |-> (p_comb[LANE_W-1] == (x_r[HALF_W-1] ^ y_r[HALF_W-1])));

  // R4: a zero lower half on Y leaves the lower lane zero, whatever the other lane does
  assert_lane_isolation_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_e == MODE_SPLIT && y_r[HALF_W-1:0] == '0)
      |-> (p_comb[LANE_W-1:0] == '0));
endmodule

// File: tb/dual_mode_mult_tb_top.sv
module dual_mode_mult_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        ce;
  logic        split_mode;
  logic        x_signed;
  logic        y_signed;
  logic [17:0] x_in;
  logic [17:0] y_in;
  logic [35:0] p_two;
  logic [35:0] p_one;
  logic [35:0] p_zero;

  int n_checks = 0;
  int n_fail   = 0;

  dual_mode_mult #(.IN_REG(1'b1), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .split_mode(split_mode),
    .x_signed(x_signed), .y_signed(y_signed), .x_in(x_in), .y_in(y_in),
    .product(p_two));

  dual_mode_mult #(.IN_REG(1'b1), .OUT_REG(1'b0)) dut_in_only_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .split_mode(split_mode),
    .x_signed(x_signed), .y_signed(y_signed), .x_in(x_in), .y_in(y_in),
    .product(p_one));

  dual_mode_mult #(.IN_REG(1'b0), .OUT_REG(1'b0)) dut_comb_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .split_mode(split_mode),
    .x_signed(x_signed), .y_signed(y_signed), .x_in(x_in), .y_in(y_in),
    .product(p_zero));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [35:0] model(input logic md, input logic xs, input logic ys,
                                        input logic [17:0] a, input logic [17:0] b);
    longint ax;
    longint bx;
    longint r;
    logic [35:0] res;
    if (!md) begin
      ax = xs ? longint'($signed(a)) : longint'({46'b0, a});
      bx = ys ? longint'($signed(b)) : longint'({46'b0, b});
      r = ax * bx;
      res = r[35:0];
    end else begin
      for (int g = 0; g < 2; g++) begin
        ax = xs ? longint'($signed(a[g*9 +: 9])) : longint'({55'b0, a[g*9 +: 9]});
        bx = ys ? longint'($signed(b[g*9 +: 9])) : longint'({55'b0, b[g*9 +: 9]});
        r = ax * bx;
        res[g*18 +: 18] = r[17:0];
      end
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic md, input logic xs, input logic ys,
                       input logic [17:0] a, input logic [17:0] b);
    split_mode = md; x_signed = xs; y_signed = ys; x_in = a; y_in = b;
  endtask

  // apply one vector and check every instance at its own latency
  task automatic run_vec(input string req, input logic md, input logic xs, input logic ys,
                         input logic [17:0] a, input logic [17:0] b);
    logic [35:0] e;
    e = model(md, xs, ys, a, b);
    @(negedge clk);
    drive(md, xs, ys, a, b);
    #1 check({req, " comb"}, p_zero, e);
    @(negedge clk); #1 check({req, " one-stage"}, p_one, e);
    @(negedge clk); #1 check({req, " two-stage"}, p_two, e);
  endtask

  task automatic t_reset();
    #1 check("R7 reset two-stage", p_two, 36'h0);
    check("R7 reset one-stage", p_one, 36'h0);
  endtask

  task automatic t_wide();
    run_vec("R1 unsigned", 1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h3FFFF);
    run_vec("R1 signed",   1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h20000);
    run_vec("R1 mixed",    1'b0, 1'b1, 1'b0, 18'h3FFF0, 18'h00123);
    run_vec("R1 y-signed", 1'b0, 1'b0, 1'b1, 18'h12345, 18'h2ABCD);
  endtask

  task automatic t_split();
    run_vec("R2 placement", 1'b1, 1'b0, 1'b0, {9'd17, 9'd5}, {9'd3, 9'd11});
    run_vec("R3 both signed", 1'b1, 1'b1, 1'b1, {9'h1FF, 9'h100}, {9'h002, 9'h1FF});
    run_vec("R3 x signed only", 1'b1, 1'b1, 1'b0, {9'h180, 9'h1FE}, {9'h1FF, 9'h003});
  endtask

  task automatic t_isolation();
    // lower lane negative, upper lane must be unaffected
    run_vec("R4 low negative", 1'b1, 1'b1, 1'b1, {9'd0, 9'h1FF}, {9'd7, 9'd100});
    // upper lane at maximum magnitude, lower lane zero
    run_vec("R4 high full", 1'b1, 1'b0, 1'b0, {9'h1FF, 9'd0}, {9'h1FF, 9'd0});
  endtask

  task automatic t_stream();
    logic [35:0] e [0:7];
    logic [17:0] a;
    logic [17:0] b;
    for (int i = 0; i < 8; i++) begin
      a = 18'(i * 7919 + 13);
      b = 18'(i * 104729 + 5);
      e[i] = model(i[0], i[1], i[2], a, b);
      @(negedge clk);
      drive(i[0], i[1], i[2], a, b);
      #1 check("R5 zero latency", p_zero, e[i]);
      if (i >= 1) check("R5 one-cycle latency", p_one, e[i-1]);
      if (i >= 2) check("R5 two-cycle latency", p_two, e[i-2]);
    end
  endtask

  task automatic t_ce_hold();
    logic [35:0] e;
    e = model(1'b0, 1'b0, 1'b0, 18'd1000, 18'd77);
    run_vec("R6 preload", 1'b0, 1'b0, 1'b0, 18'd1000, 18'd77);
    @(negedge clk);
    ce = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 18'h3FFFF, 18'h15555);
    repeat (3) @(negedge clk);
    #1 check("R6 hold two-stage", p_two, e);
    check("R6 hold one-stage", p_one, e);
    ce = 1'b1;
  endtask

  task automatic t_clear();
    logic [35:0] e;
    e = model(1'b0, 1'b1, 1'b1, 18'h2F00F, 18'h00321);
    run_vec("R7 preload", 1'b0, 1'b1, 1'b1, 18'h2F00F, 18'h00321);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R7 async clear two-stage", p_two, 36'h0);
    check("R7 async clear one-stage", p_one, 36'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R7 held after release", p_two, 36'h0);
    repeat (4) @(negedge clk);
    #1 check("R7 resumed two-stage", p_two, e);
    check("R7 resumed one-stage", p_one, e);
  endtask

  initial begin
    rst_n = 1'b1;
    ce = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 18'd0, 18'd0);
    #3 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_wide();
    t_split();
    t_isolation();
    t_stream();
    t_ce_hold();
    t_clear();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule